// File: doc/BRIEF.md
# Cascadable Parallel-Load Serial-Out Shift Register

This block captures a word of parallel data and then hands it out one bit at a time on a serial output. It lives in a single system-clock domain. The strobe, the parallel data, the serial cascade input and both shift-clock pins are treated as synchronous inputs that are sampled on each system clock. Shift-clock edges are found inside the block by comparing each sample with the one taken in the previous cycle.

While the active-low load strobe is asserted, the register follows the parallel inputs, and the top data bit shows up on the serial output in the same cycle. Once the strobe is released, the captured word is held. Each rising edge of the effective shift clock then moves the word one stage toward the last stage. The effective shift clock is the OR of the shift-clock pin and the active-low clock-enable pin. The cascade input fills the first stage, so a chain of these blocks reads out as one long word.

A host reads the block in three steps. It pulses the load strobe low, then holds it high, then delivers WIDTH clock edges, either on the shift-clock pin with the enable held low, or on the enable pin with the shift clock held low.

Top module: `piso_cascade`

## Requirements
- R1: While `load_n` is 0, every system clock copies `par_in` into the stages, and `q_last` equals `par_in[WIDTH-1]` combinationally in the same cycle.
- R2: While `load_n` is 0, the pins `shclk`, `shclk_en_n` and `ser_in` have no effect on the word that is held once loading ends.
- R3: After `load_n` returns to 1, the held word is the last `par_in` sampled while `load_n` was 0. Later changes on `par_in` have no effect.
- R4: A shift occurs when `load_n` is 1 and the effective clock (`shclk | shclk_en_n`) is 1 now but was 0 at the previous system clock. Each stage i takes stage i-1, stage 0 takes `ser_in`, and `q_last` shows the top stage. After a load, `q_last` therefore presents the loaded bits from `par_in[WIDTH-1]` down to `par_in[0]`.
- R5: While `shclk_en_n` is 1, toggling `shclk` causes no shift.
- R6: While `shclk` is held at 0, a 0-to-1 transition of `shclk_en_n` causes exactly one shift.
- R7: An effective clock held at 1 over many system clocks causes only one shift.
- R8: `q_last_n` is always the complement of `q_last`.
- R9: After WIDTH shifts, `q_last` presents the `ser_in` bits in the order they were shifted in. This allows cascading.
- R10: A synchronous `rst` clears all stages, so `q_last` reads 0 while `load_n` is 1. An effective clock that is already 1 when reset is released does not cause a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel-load strobe, active low |
| par_in | input | WIDTH | Parallel data, bit WIDTH-1 leaves first |
| ser_in | input | 1 | Cascade input into stage 0 |
| shclk | input | 1 | Shift clock, active on rising edge |
| shclk_en_n | input | 1 | Clock enable, active low; ORed with shclk |
| q_last | output | 1 | Last stage (serial output) |
| q_last_n | output | 1 | Complement of the last stage |

## Verification
The assertions check the following on every cycle:
- capture of the parallel word during loading;
- the one-stage shift on each detected edge of the effective clock;
- that no stage changes when there is no edge;
- that the two outputs are complementary;
- that reset clears the stages.

Some behaviours only the bench's scenarios can show:
- the full read-out order of every 8-bit pattern, in both clocking styles;
- the cascade bits appearing after the word;
- that the enable blocks the clock;
- that activity during loading is ignored;
- that no spurious shift happens when reset is released with the clock high.

// File: rtl/piso_cascade.sv
module piso_cascade #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic             shclk,
  input  logic             shclk_en_n,
  output logic             q_last,
  output logic             q_last_n
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] stage;
  logic             eff_prev;
  logic             eff_now;
  logic             edge_seen;

  assign eff_now   = shclk | shclk_en_n;
  assign edge_seen = eff_now & ~eff_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage    <= '0;
      eff_prev <= 1'b1;
    end else begin
      eff_prev <= eff_now;
      if (!load_n)
        stage <= par_in;
      else if (edge_seen)
        stage <= {stage[TOP-1:0], ser_in};
    end
  end

  assign q_last   = load_n ? stage[TOP] : par_in[TOP];
  assign q_last_n = ~q_last;
endmodule

module piso_cascade_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load_n,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_in,
  input logic             shclk,
  input logic             shclk_en_n,
  input logic             q_last,
  input logic             q_last_n,
  input logic [WIDTH-1:0] stage
);
  logic seen_q;
  logic rise_c;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b1;
    else     seen_q <= shclk | shclk_en_n;
  end
  assign rise_c = (shclk | shclk_en_n) & ~seen_q;

  p_load_capture_r1: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> stage == $past(par_in));

  p_load_out_r1: assert property (@(posedge clk) disable iff (rst)
    !load_n |-> q_last == par_in[WIDTH-1]);

  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (load_n && rise_c) |=> stage == {$past(stage[WIDTH-2:0]), $past(ser_in)});

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (load_n && !rise_c) |=> $stable(stage));

  p_last_stage_r4: assert property (@(posedge clk) disable iff (rst)
    load_n |-> q_last == stage[WIDTH-1]);

  p_compl_r8: assert property (@(posedge clk) disable iff (rst)
    q_last_n != q_last);

  p_reset_r10: assert property (@(posedge clk)
    rst |=> stage == '0);
endmodule

bind piso_cascade piso_cascade_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .load_n(load_n), .par_in(par_in), .ser_in(ser_in),
  .shclk(shclk), .shclk_en_n(shclk_en_n), .q_last(q_last),
  .q_last_n(q_last_n), .stage(stage)
);

// File: tb/tb_piso_cascade.sv
module tb_piso_cascade;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_n = 1'b1;
  logic [W-1:0] par_in = '0;
  logic         ser_in = 1'b0;
  logic         shclk = 1'b0;
  logic         shclk_en_n = 1'b0;
  logic         q_last, q_last_n;

  int n_chk = 0;
  int n_bad = 0;
  bit use_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  piso_cascade #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .load_n(load_n), .par_in(par_in), .ser_in(ser_in),
    .shclk(shclk), .shclk_en_n(shclk_en_n), .q_last(q_last), .q_last_n(q_last_n)
  );

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit exp, input string tag);
    n_chk++;
    if (q_last !== exp) begin
      n_bad++;
      $display("FAIL %s: q_last=%b expected %b", tag, q_last, exp);
    end
    n_chk++;
    if (q_last_n !== ~exp) begin
      n_bad++;
      $display("FAIL R8 (%s): q_last_n=%b expected %b", tag, q_last_n, ~exp);
    end
  endtask

  task automatic pulse();
    if (use_en) shclk_en_n = 1'b1; else shclk = 1'b1;
    step();
    if (use_en) shclk_en_n = 1'b0; else shclk = 1'b0;
    step();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R10: reset with the effective clock already high
    rst = 1'b1; shclk = 1'b1; ser_in = 1'b1; load_n = 1'b1;
    step(); step();
    check(1'b0, "R10 reset clears");
    rst = 1'b0;
    step();
    ser_in = 1'b0; shclk = 1'b0;
    step();
    use_en = 1'b0;
    for (int k = 0; k < W - 1; k++) pulse();
    check(1'b0, "R10 no spurious shift after reset");

    // exhaustive sweep: all patterns, both clocking styles (R1-R4, R6, R9)
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 256; i++) begin
        logic [W-1:0] p;
        logic [W-1:0] s;
        p = W'(i);
        s = p ^ 8'h5A ^ W'(m * 8'hFF);
        use_en = (m == 1);
        shclk = 1'b0; shclk_en_n = 1'b0;
        load_n = 1'b0; par_in = ~p;
        step();
        check(~p[W-1], "R1 transparent load");
        par_in = p;
        #1;
        check(p[W-1], "R1 same-cycle follow");
        // R2: clock and cascade activity while loading is ignored
        shclk = 1'b1; shclk_en_n = 1'b1; ser_in = 1'b1;
        step();
        shclk = 1'b0; shclk_en_n = 1'b0; ser_in = 1'b0;
        step();
        load_n = 1'b1;
        step();
        par_in = ~p;
        step();
        check(p[W-1], "R3 held word after load release");
        for (int k = 0; k < W; k++) begin
          check(p[W-1-k], use_en ? "R6/R4 read-out via enable" : "R4/R2 read-out via shclk");
          ser_in = s[k];
          pulse();
        end
        for (int j = 0; j < W; j++) begin
          check(s[j], "R9 cascade bits follow word");
          ser_in = 1'b0;
          pulse();
        end
      end
    end

    // R5: enable high blocks shclk
    use_en = 1'b0;
    shclk = 1'b0; shclk_en_n = 1'b1;
    load_n = 1'b0; par_in = 8'h80;
    step();
    load_n = 1'b1;
    step();
    for (int k = 0; k < 3; k++) begin
      shclk = 1'b1; step();
      shclk = 1'b0; step();
    end
    check(1'b1, "R5 enable high blocks clock");

    // R7: held-high clock shifts once only
    shclk_en_n = 1'b0; shclk = 1'b0;
    load_n = 1'b0; par_in = 8'hC0;
    step();
    load_n = 1'b1; ser_in = 1'b0;
    step();
    shclk = 1'b1;
    for (int k = 0; k < 4; k++) step();
    check(1'b1, "R7 single shift on held clock");
    shclk = 1'b0;
    step();
    pulse();
    check(1'b0, "R7 next edge shifts again");

    finish_run();
  end
endmodule